// File: doc/BRIEF.md
# Parallel Flash Byte Bridge

This block sits behind a memory-mapped register window and lets a host move single bytes to and from an external parallel boot flash. The host writes one command word. The word carries a byte address, a direction and a start flag. The block then drives the flash chip-select, output-enable, write-enable, address and data pins through a cycle of fixed length. During that cycle the start flag reads back as a busy indication. When the cycle ends, the flag clears by itself.

For a write cycle, the host first places the byte in the data register and then issues the command. For a read cycle, the host issues the command, polls until busy clears, and then collects the byte from the data register. A status bit in the command register reflects a flash-presence input, so software can tell whether a device is fitted. The two strobe lengths are parameters.

Top module: `pflash_byte_bridge`

## Requirements
- R1: After reset, both registers read zero apart from the presence bit (bit 26). Busy is 0, fl_ce_n, fl_oe_n and fl_we_n are high, and fl_dq_oe is low.
- R2: Command register (offset 0) layout: bits 18:0 are the byte address and bit 24 is the direction (1 = read, 0 = write). Bits 31:27 and 23:19 read as 0 and ignore writes. A command write with bit 25 clear stores the address and direction and starts no cycle.
- R3: Writing 1 to bit 25 while idle starts a cycle. Bit 25 then reads 1 for exactly RD_CYC clock cycles for a read, or WE_CYC+2 clock cycles for a write, and then returns to 0 without host action.
- R4: Command bit 26 reads the level of flash_detect. Host writes to bit 26 have no effect.
- R5: A read cycle holds fl_ce_n and fl_oe_n low for RD_CYC cycles, keeps fl_we_n high and fl_dq_oe low, and presents the command address on fl_addr. At the end it loads fl_dq_i into data register bits 7:0 and leaves bits 31:8 unchanged.
- R6: A write cycle holds fl_ce_n low for WE_CYC+2 cycles and drives fl_dq_oe with the byte on fl_dq_o for that whole span. fl_we_n is low only for the middle WE_CYC cycles, giving one cycle of setup and one of hold. fl_oe_n stays high and fl_addr is steady throughout.
- R7: A command write that arrives while busy is 1 is ignored. The address and direction stay unchanged, the running cycle keeps its length, and no second cycle follows.
- R8: Data register (offset 4) bits 31:0 are read/write storage. Only bits 7:0 reach fl_dq_o, and a write cycle leaves the data register unchanged.
- R9: fl_dq_oe is low whenever no write cycle is running.
- R10: Writes to offsets other than 0 and 4 are ignored, and reads of those offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | OFS_W | Byte offset in the register window |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data (combinational on host_addr) |
| flash_detect | input | 1 | High when a flash device is fitted |
| fl_addr | output | ADDR_W | Flash byte address |
| fl_ce_n | output | 1 | Flash chip select, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_dq_o | output | 8 | Data driven toward the flash |
| fl_dq_oe | output | 1 | Enable for the data pad driver |
| fl_dq_i | input | 8 | Data returned by the flash |

## Verification
The bench first runs directed cases: command writes with bit 25 clear, command writes with the reserved bits set, a command issued in the middle of a running read, and accesses to an unmapped offset. These separate correct field masking and busy protection from a design that merely copies the host word. A seeded random mix of reads and writes follows, using random addresses and random upper data bits. Each cycle is checked against a bench model of the flash for strobe lengths, address, driven byte and the returned byte. This shows whether read and write timing stay distinct, and whether the upper data bits ever leak onto the flash bus.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_WSU  = 3'd2,
    ST_WPL  = 3'd3,
    ST_WHD  = 3'd4
  } pfb_state_e;

  localparam int DIR_BIT = 24;
  localparam int GO_BIT  = 25;
  localparam int DET_BIT = 26;
  localparam int OFS_CMD = 0;
  localparam int OFS_DAT = 4;
endpackage

// File: rtl/pfb_regs.sv
module pfb_regs
  import pfb_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int OFS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [OFS_W-1:0]  host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  input  logic              busy,
  input  logic              detect,
  input  logic              rd_done,
  input  logic [7:0]        rd_byte,
  output logic              launch,
  output logic              launch_dir,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [7:0]        data_byte
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              dir_q, dir_d;
  logic [31:0]       data_q, data_d;
  logic              cmd_hit, dat_hit, cmd_en, dat_en;
  logic              unused_bits;

  assign cmd_hit = host_we && (host_addr == OFS_W'(OFS_CMD));
  assign dat_hit = host_we && (host_addr == OFS_W'(OFS_DAT));
  assign cmd_en  = cmd_hit && !busy;
  assign dat_en  = dat_hit || rd_done;

  assign launch     = cmd_en && host_wdata[GO_BIT];
  assign launch_dir = host_wdata[DIR_BIT];
  assign unused_bits = ^{host_wdata[31:DET_BIT], host_wdata[23:ADDR_W]};

  always_comb begin
    addr_d = addr_q;
    dir_d  = dir_q;
    if (cmd_en) begin
      addr_d = host_wdata[ADDR_W-1:0];
      dir_d  = host_wdata[DIR_BIT];
    end
  end

  always_comb begin
    data_d = data_q;
    if (dat_hit) data_d = host_wdata;
    if (rd_done) data_d[7:0] = rd_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      dir_q  <= 1'b0;
    end else if (cmd_en) begin
      addr_q <= addr_d;
      dir_q  <= dir_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else if (dat_en) data_q <= data_d;
  end

  always_comb begin
    host_rdata = '0;
    if (host_addr == OFS_W'(OFS_CMD)) begin
      host_rdata[ADDR_W-1:0] = addr_q;
      host_rdata[DIR_BIT]    = dir_q;
      host_rdata[GO_BIT]     = busy;
      host_rdata[DET_BIT]    = detect;
    end else if (host_addr == OFS_W'(OFS_DAT)) begin
      host_rdata = data_q;
    end
  end

  assign cmd_addr  = addr_q;
  assign data_byte = data_q[7:0];

  AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_hit) |=> ($stable(addr_q) && $stable(dir_q))); // R7
  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !dat_hit) |=> $stable(data_q[31:8])); // R5
endmodule

// File: rtl/pfb_seq.sv
module pfb_seq
  import pfb_pkg::*;
#(
  parameter int RD_CYC = 4,
  parameter int WE_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch,
  input  logic       launch_dir,
  output pfb_state_e state,
  output logic       busy,
  output logic       rd_done
);
  localparam int CNT_MAX = (RD_CYC > WE_CYC) ? RD_CYC : WE_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  pfb_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    rd_done = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (launch) st_d = launch_dir ? ST_RD : ST_WSU;
      end
      ST_RD: begin
        if (cnt_q == CNT_W'(RD_CYC - 1)) begin
          st_d    = ST_IDLE;
          cnt_d   = '0;
          rd_done = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_WSU: begin
        st_d  = ST_WPL;
        cnt_d = '0;
      end
      ST_WPL: begin
        if (cnt_q == CNT_W'(WE_CYC - 1)) begin
          st_d  = ST_WHD;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_WHD: st_d = ST_IDLE;
      default: begin
        st_d  = ST_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state = st_q;
  assign busy  = (st_q != ST_IDLE);

  AST_RD_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RD) |-> (cnt_q < CNT_W'(RD_CYC))); // R3
  AST_WE_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WPL) |-> (cnt_q < CNT_W'(WE_CYC))); // R3
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !busy); // R3
endmodule

// File: rtl/pfb_pins.sv
module pfb_pins
  import pfb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pfb_state_e state,
  input  logic       launch,
  input  logic [7:0] data_byte,
  output logic       ce_n,
  output logic       oe_n,
  output logic       we_n,
  output logic [7:0] dq_o,
  output logic       dq_oe
);
  logic [7:0] wbyte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wbyte_q <= '0;
    else if (launch) wbyte_q <= data_byte;
  end

  always_comb begin
    ce_n  = 1'b1;
    oe_n  = 1'b1;
    we_n  = 1'b1;
    dq_oe = 1'b0;
    unique case (state)
      ST_RD: begin
        ce_n = 1'b0;
        oe_n = 1'b0;
      end
      ST_WSU, ST_WHD: begin
        ce_n  = 1'b0;
        dq_oe = 1'b1;
      end
      ST_WPL: begin
        ce_n  = 1'b0;
        we_n  = 1'b0;
        dq_oe = 1'b1;
      end
      default: ;
    endcase
  end

  assign dq_o = wbyte_q;

  AST_WE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (dq_oe && !ce_n && oe_n)); // R6
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !dq_oe); // R9
  AST_BYTE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(dq_oe)) |-> $stable(dq_o)); // R8
endmodule

// File: rtl/pflash_byte_bridge.sv
module pflash_byte_bridge
  import pfb_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int OFS_W  = 8,
  parameter int RD_CYC = 4,
  parameter int WE_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [OFS_W-1:0]  host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  input  logic              flash_detect,
  output logic [ADDR_W-1:0] fl_addr,
  output logic              fl_ce_n,
  output logic              fl_oe_n,
  output logic              fl_we_n,
  output logic [7:0]        fl_dq_o,
  output logic              fl_dq_oe,
  input  logic [7:0]        fl_dq_i
);
  pfb_state_e state;
  logic       busy, rd_done, launch, launch_dir;
  logic [7:0] data_byte;

  pfb_regs #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .busy       (busy),
    .detect     (flash_detect),
    .rd_done    (rd_done),
    .rd_byte    (fl_dq_i),
    .launch     (launch),
    .launch_dir (launch_dir),
    .cmd_addr   (fl_addr),
    .data_byte  (data_byte)
  );

  pfb_seq #(.RD_CYC(RD_CYC), .WE_CYC(WE_CYC)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch),
    .launch_dir (launch_dir),
    .state      (state),
    .busy       (busy),
    .rd_done    (rd_done)
  );

  pfb_pins u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .launch    (launch),
    .data_byte (data_byte),
    .ce_n      (fl_ce_n),
    .oe_n      (fl_oe_n),
    .we_n      (fl_we_n),
    .dq_o      (fl_dq_o),
    .dq_oe     (fl_dq_oe)
  );

  AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_ce_n && $past(!fl_ce_n)) |-> $stable(fl_addr)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (fl_ce_n && !fl_dq_oe)); // R9
endmodule

// File: tb/pflash_byte_bridge_test.sv
module pflash_byte_bridge_test;
  localparam int ADDR_W = 19;
  localparam int RD_CYC = 4;
  localparam int WE_CYC = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              host_we = 1'b0;
  logic [7:0]        host_addr = '0;
  logic [31:0]       host_wdata = '0;
  logic [31:0]       host_rdata;
  logic              flash_detect = 1'b1;
  logic [ADDR_W-1:0] fl_addr;
  logic              fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe;
  logic [7:0]        fl_dq_o, fl_dq_i;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] shadow_dat = '0;

  always #10 clk = ~clk;

  function automatic logic [7:0] flash_byte(input logic [ADDR_W-1:0] a);
    return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 8'h5A;
  endfunction

  assign fl_dq_i = (!fl_ce_n && !fl_oe_n) ? flash_byte(fl_addr) : 8'hFF;

  pflash_byte_bridge #(.ADDR_W(ADDR_W), .RD_CYC(RD_CYC), .WE_CYC(WE_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .flash_detect(flash_detect),
    .fl_addr(fl_addr), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n),
    .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  function automatic logic [31:0] cmd_word(input bit go, input bit dir, input logic [ADDR_W-1:0] a);
    return 32'hF8F8_0000 | (32'(go) << 25) | (32'(dir) << 24) | 32'(a);
  endfunction

  function automatic logic [31:0] cmd_view(input bit dir, input logic [ADDR_W-1:0] a);
    return (32'(flash_detect) << 26) | (32'(dir) << 24) | 32'(a);
  endfunction

  task automatic xfer(input bit is_rd, input logic [ADDR_W-1:0] a, input bit poke);
    logic [31:0] c;
    int nbusy = 0, nce = 0, noe = 0, nwe = 0, ndq = 0, bad_addr = 0;
    logic [7:0] wbyte = 8'h00;
    bit wseen = 1'b0;
    wr(8'h00, cmd_word(1'b1, is_rd, a));
    for (int i = 0; i < 50; i++) begin
      rd(8'h00, c);
      if (!c[25]) break;
      nbusy++;
      if (!fl_ce_n) nce++;
      if (!fl_oe_n) noe++;
      if (fl_dq_oe) ndq++;
      if (!fl_ce_n && fl_addr !== a) bad_addr++;
      if (!fl_we_n) begin nwe++; wbyte = fl_dq_o; wseen = 1'b1; end
      if (poke && i == 1) begin
        host_wdata = cmd_word(1'b1, !is_rd, ~a);
        host_we = 1'b1;
      end
      @(negedge clk);
      host_we = 1'b0;
    end
    chk(is_rd ? "R3 read busy length" : "R3 write busy length",
        nbusy, is_rd ? RD_CYC : WE_CYC + 2);
    chk("R5/R6 chip select length", nce, is_rd ? RD_CYC : WE_CYC + 2);
    chk("R5/R6 output enable length", noe, is_rd ? RD_CYC : 0);
    chk("R5/R6 write enable length", nwe, is_rd ? 0 : WE_CYC);
    chk("R6/R9 data drive length", ndq, is_rd ? 0 : WE_CYC + 2);
    chk("R5/R6 address on pins", bad_addr, 0);
    rd(8'h00, c);
    chk("R2 command readback", c, cmd_view(is_rd, a));
    if (is_rd) shadow_dat[7:0] = flash_byte(a);
    else if (wseen) chk("R8 written byte", {24'h0, wbyte}, {24'h0, shadow_dat[7:0]});
    rd(8'h04, c);
    chk(is_rd ? "R5 read byte in data reg" : "R8 data reg kept", c, shadow_dat);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] c;
    void'($urandom(32'h0BAD_5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(8'h00, c); chk("R1 command after reset", c, 32'h0400_0000);
    rd(8'h04, c); chk("R1 data after reset", c, 32'h0);
    chk("R1 strobes idle", {fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe}, 4'b1110);
    // R2 store without start, reserved bits masked
    wr(8'h00, cmd_word(1'b0, 1'b1, 19'h5_A5A5));
    rd(8'h00, c); chk("R2 store no start", c, cmd_view(1'b1, 19'h5_A5A5));
    @(negedge clk);
    chk("R2 no cycle started", {31'h0, fl_ce_n}, 32'h1);
    // R4 presence bit
    flash_detect = 1'b0;
    rd(8'h00, c); chk("R4 detect low", {31'h0, c[26]}, 32'h0);
    wr(8'h00, 32'h0400_0000);
    rd(8'h00, c); chk("R4 write ignored", {31'h0, c[26]}, 32'h0);
    flash_detect = 1'b1;
    rd(8'h00, c); chk("R4 detect high", {31'h0, c[26]}, 32'h1);
    // R10 unmapped offset
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, c); chk("R10 unmapped reads zero", c, 32'h0);
    rd(8'h00, c); chk("R10 command untouched", c, cmd_view(1'b0, 19'h0));
    rd(8'h04, c); chk("R10 data untouched", c, 32'h0);
    // R8 data storage
    shadow_dat = 32'hCAFE_D00D;
    wr(8'h04, shadow_dat);
    rd(8'h04, c); chk("R8 data storage", c, shadow_dat);
    // directed cycles at address edges
    xfer(1'b0, 19'h7_FFFF, 1'b0);
    xfer(1'b1, 19'h7_FFFF, 1'b0);
    xfer(1'b1, 19'h0_0000, 1'b0);
    // R7 command during busy
    xfer(1'b1, 19'h1_2345, 1'b1);
    repeat (2) @(negedge clk);
    rd(8'h00, c);
    chk("R7 no second cycle", {30'h0, c[25], fl_ce_n}, 32'h1);
    shadow_dat = 32'h1234_5600;
    wr(8'h04, shadow_dat);
    xfer(1'b0, 19'h0_0001, 1'b1);
    // random mix
    for (int k = 0; k < 40; k++) begin
      logic [ADDR_W-1:0] a;
      bit d;
      a = ADDR_W'($urandom);
      d = 1'($urandom);
      if (!d) begin
        shadow_dat = $urandom;
        wr(8'h04, shadow_dat);
      end
      xfer(d, a, 1'b0);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule